// File: doc/BRIEF.md
# Atomic-Sequence Memory Arbiter

This block sits in front of one shared word memory and lets several requester ports reach it. One request is served per cycle. While no atomic sequence is open, pending ports take turns in round-robin order. Every request carries one extra flag bit. When a port is granted a request with the flag set, that request is served and the memory is then held for that port alone. Every other port stalls, with its valid held high and its ready low, until the holding port is granted a request with the flag clear. That closing request is served, and the hold is then released.

A sequence of N accesses is therefore sent as N-1 flagged requests followed by one unflagged request. A typical use is test-and-set: a port reads a flag word with the bit set, checks the value it gets back, and writes the flag with the bit clear. No other port can touch the memory between the read and the write.

Handshakes are per port. Ready is combinational and is raised in the cycle of the grant. A write lands at the edge that ends its grant cycle. Read data comes back on a shared data bus one cycle after the grant, marked by a per-port strobe.

Top module: `atomic_mem_arbiter`

## Requirements
- R1: After reset no hold is open and rd_valid is all zero. With no valid input, ready is all zero. The first arbitration after reset, with every port valid, grants port 0.
- R2: At most one ready bit is high in any cycle. A ready bit is high only when that port's valid is high, and it is raised combinationally in the same cycle.
- R3: With no hold open, the grant goes to the first valid port at or after the port that follows the last granted port, wrapping from the highest port number to port 0.
- R4: A granted write (write=1) updates the word at its address at the end of the grant cycle. A granted read (write=0) raises rd_valid of that port for exactly the next cycle, and rd_data then holds the word at the requested address.
- R5: A granted request with atomic=1 opens a hold for its port. Until the hold ends, no other port sees ready, even while its valid is high.
- R6: A granted request from the holding port with atomic=0 is served, and the hold ends after it. From the next cycle other ports are arbitrated again.
- R7: A granted request with atomic=0 while no hold is open leaves the arbiter unlocked, so a different port can be granted in the next cycle.
- R8: The holding port may send any number of further atomic=1 requests. Each is granted, and the hold stays open.
- R9: When two ports contend with test-and-set sequences on the same flag word, exactly one of them reads the flag clear. The other is served only after the first one's closing write, and reads the flag set.
- R10: Cycles in which the holding port has no valid request do not end the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port request valid |
| req_ready | output | NUM_PORTS | Per-port grant, high in the cycle the request is taken |
| req_write | input | NUM_PORTS | Per-port access kind: 1 write, 0 read |
| req_atomic | input | NUM_PORTS | Per-port atomicity flag: 1 keeps or opens the hold, 0 ends it |
| req_addr | input | NUM_PORTS*ADDR_W | Word addresses, port p at bits [p*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_PORTS*DATA_W | Write data, port p at bits [p*DATA_W +: DATA_W] |
| rd_valid | output | NUM_PORTS | Per-port read-return strobe, one cycle after a read grant |
| rd_data | output | DATA_W | Shared read-return data |

## Verification
The bench targets the round-robin wrap when only ports 0 and 2 request. A pointer that failed to skip idle ports or restarted at port 0 would grant port 0 twice in a row. It holds competing ports valid through a hold, including cycles in which the owner is idle. A design that let the hold lapse on an idle cycle, or that arbitrated other ports during it, would raise a stranger's ready there. It also runs two ports through contending test-and-set sequences. A lock that opened a cycle late, or a release that came before the closing write was served, would let both ports read the flag clear.

// File: rtl/atomarb_pkg.sv
package atomarb_pkg;

   typedef enum logic {
      HOLD_FREE = 1'b0,
      HOLD_BUSY = 1'b1
   } hold_state_e;

endpackage

// File: rtl/atomarb_pick.sv
module atomarb_pick #(
   parameter int NUM_PORTS = 3,
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [IDX_W-1:0]     start_idx,
   input  logic [NUM_PORTS-1:0] eligible,
   output logic [NUM_PORTS-1:0] gnt,
   output logic [IDX_W-1:0]     gnt_idx,
   output logic                 gnt_any
);

   localparam int SUM_W = IDX_W + 1;

   logic [SUM_W-1:0] pos;
   logic             found;

   always_comb begin
      gnt   = '0;
      found = 1'b0;
      pos   = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         pos = {1'b0, start_idx} + SUM_W'(k);
         if (pos >= SUM_W'(NUM_PORTS)) begin
            pos = pos - SUM_W'(NUM_PORTS);
         end
         if (!found && eligible[pos[IDX_W-1:0]]) begin
            gnt[pos[IDX_W-1:0]] = 1'b1;
            found = 1'b1;
         end
      end
   end

   always_comb begin
      gnt_idx = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         if (gnt[k]) begin
            gnt_idx = IDX_W'(k);
         end
      end
   end

   assign gnt_any = found;

endmodule

// File: rtl/atomarb_state.sv
module atomarb_state
   import atomarb_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gnt_any,
   input  logic [IDX_W-1:0] gnt_idx,
   input  logic             gnt_atomic,
   output logic             held,
   output logic [IDX_W-1:0] owner,
   output logic [IDX_W-1:0] next_start
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

   hold_state_e      st_q;
   logic [IDX_W-1:0] owner_q;
   logic [IDX_W-1:0] start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= HOLD_FREE;
         owner_q <= '0;
         start_q <= '0;
      end else if (gnt_any) begin
         start_q <= (gnt_idx == LAST_IDX) ? '0 : gnt_idx + 1'b1;
         if (gnt_atomic) begin
            st_q    <= HOLD_BUSY;
            owner_q <= gnt_idx;
         end else begin
            st_q    <= HOLD_FREE;
         end
      end
   end

   assign held       = (st_q == HOLD_BUSY);
   assign owner      = owner_q;
   assign next_start = start_q;

endmodule

// File: rtl/atomarb_mem.sv
module atomarb_mem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         cells[addr] <= wdata;
      end
      if (rd_en) begin
         rdata <= cells[addr];
      end
   end

endmodule

// File: rtl/atomic_mem_arbiter.sv
module atomic_mem_arbiter #(
   parameter int NUM_PORTS = 3,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        req_valid,
   output logic [NUM_PORTS-1:0]        req_ready,
   input  logic [NUM_PORTS-1:0]        req_write,
   input  logic [NUM_PORTS-1:0]        req_atomic,
   input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
   input  logic [NUM_PORTS*DATA_W-1:0] req_wdata,
   output logic [NUM_PORTS-1:0]        rd_valid,
   output logic [DATA_W-1:0]           rd_data
);

   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("atomic_mem_arbiter: NUM_PORTS must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("atomic_mem_arbiter: ADDR_W must be 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("atomic_mem_arbiter: DATA_W must be positive");
   end

   logic                 lock_held;
   logic [IDX_W-1:0]     lock_owner;
   logic [IDX_W-1:0]     rr_start;
   logic [NUM_PORTS-1:0] owner_mask;
   logic [NUM_PORTS-1:0] eligible;
   logic [NUM_PORTS-1:0] gnt;
   logic [IDX_W-1:0]     gnt_idx;
   logic                 gnt_any;
   logic                 sel_write;
   logic                 sel_atomic;
   logic [ADDR_W-1:0]    sel_addr;
   logic [DATA_W-1:0]    sel_wdata;
   logic [NUM_PORTS-1:0] rd_valid_q;

   // While a hold is open only the owner is offered to the picker.
   assign owner_mask = NUM_PORTS'(1) << lock_owner;
   assign eligible   = lock_held ? (req_valid & owner_mask) : req_valid;

   atomarb_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
      .start_idx (rr_start),
      .eligible  (eligible),
      .gnt       (gnt),
      .gnt_idx   (gnt_idx),
      .gnt_any   (gnt_any)
   );

   // One-hot field select of the granted port.
   always_comb begin
      sel_write  = 1'b0;
      sel_atomic = 1'b0;
      sel_addr   = '0;
      sel_wdata  = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         sel_write  = sel_write  | (gnt[p] & req_write[p]);
         sel_atomic = sel_atomic | (gnt[p] & req_atomic[p]);
         sel_addr   = sel_addr   | ({ADDR_W{gnt[p]}} & req_addr[p*ADDR_W +: ADDR_W]);
         sel_wdata  = sel_wdata  | ({DATA_W{gnt[p]}} & req_wdata[p*DATA_W +: DATA_W]);
      end
   end

   atomarb_state #(.NUM_PORTS(NUM_PORTS)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .gnt_any    (gnt_any),
      .gnt_idx    (gnt_idx),
      .gnt_atomic (sel_atomic),
      .held       (lock_held),
      .owner      (lock_owner),
      .next_start (rr_start)
   );

   atomarb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .wr_en (gnt_any & sel_write),
      .rd_en (gnt_any & ~sel_write),
      .addr  (sel_addr),
      .wdata (sel_wdata),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_q <= '0;
      end else begin
         rd_valid_q <= gnt & ~req_write;
      end
   end

   assign req_ready = gnt;
   assign rd_valid  = rd_valid_q;

endmodule

// File: rtl/atomarb_chk.sv
module atomarb_chk #(
   parameter int NUM_PORTS = 3,
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PORTS-1:0] req_valid,
   input logic [NUM_PORTS-1:0] req_ready,
   input logic [NUM_PORTS-1:0] req_write,
   input logic [NUM_PORTS-1:0] req_atomic,
   input logic [NUM_PORTS-1:0] rd_valid,
   input logic                 locked,
   input logic [IDX_W-1:0]     owner
);

   logic [NUM_PORTS-1:0] own_mask;
   assign own_mask = NUM_PORTS'(1) << owner;

   // R2
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   // R2
   ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);

   // R5
   hold_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(req_ready & req_atomic) |=> locked);

   // R5
   stranger_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (req_ready & ~own_mask) == '0);

   // R6
   hold_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && |(req_ready & ~req_atomic)) |=> !locked);

   // R10
   idle_owner_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && req_ready == '0) |=> (locked && $stable(owner)));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      // R4
      read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_ready[p] && !req_write[p]) |=> rd_valid[p]);

      // R4
      return_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid[p] |-> $past(req_ready[p] && !req_write[p]));
   end

endmodule

bind atomic_mem_arbiter atomarb_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_atomic (req_atomic),
   .rd_valid   (rd_valid),
   .locked     (lock_held),
   .owner      (lock_owner)
);

// File: tb/atomic_mem_arbiter_test.sv
module atomic_mem_arbiter_test;

   localparam int NP = 3;
   localparam int AW = 4;
   localparam int DW = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    valid = '0;
   logic [NP-1:0]    ready;
   logic [NP-1:0]    write = '0;
   logic [NP-1:0]    atomic = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP*DW-1:0] wdata = '0;
   logic [NP-1:0]    rd_valid;
   logic [DW-1:0]    rd_data;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   atomic_mem_arbiter #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (valid),
      .req_ready  (ready),
      .req_write  (write),
      .req_atomic (atomic),
      .req_addr   (addr),
      .req_wdata  (wdata),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(int p, bit w, bit a, logic [AW-1:0] ad, logic [DW-1:0] d);
      valid[p]            = 1'b1;
      write[p]            = w;
      atomic[p]           = a;
      addr[p*AW +: AW]    = ad;
      wdata[p*DW +: DW]   = d;
   endtask

   task automatic drop(int p);
      valid[p] = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      repeat (3) tick();
      rst_n = 1'b1;
      #1;
      check("R1 ready idle after reset", 32'(ready), 32'h0);
      check("R1 rd_valid after reset", 32'(rd_valid), 32'h0);
   endtask

   task automatic t_round_robin();
      logic [NP-1:0] exp_a [4] = '{3'b001, 3'b010, 3'b100, 3'b001};
      logic [NP-1:0] exp_b [3] = '{3'b100, 3'b001, 3'b100};
      for (int p = 0; p < NP; p++) put(p, 1'b1, 1'b0, AW'(p), DW'(8'hA0 + p));
      for (int i = 0; i < 4; i++) begin
         #1;
         check(i == 0 ? "R1 first grant port 0" : "R3 rotation all ports", 32'(ready), 32'(exp_a[i]));
         tick();
      end
      drop(1);
      for (int i = 0; i < 3; i++) begin
         #1;
         check("R3 rotation skips idle port", 32'(ready), 32'(exp_b[i]));
         tick();
      end
      valid = '0;
      tick();
   endtask

   task automatic t_read_write();
      put(0, 1'b1, 1'b0, 4'd5, 8'h5A);
      #1;
      check("R2 lone write granted same cycle", 32'(ready), 32'h1);
      tick();
      put(0, 1'b0, 1'b0, 4'd5, 8'h00);
      #1;
      check("R4 no strobe after write", 32'(rd_valid), 32'h0);
      tick();
      valid = '0;
      check("R4 read strobe port 0", 32'(rd_valid), 32'h1);
      check("R4 read sees fresh write", 32'(rd_data), 32'h5A);
      put(1, 1'b0, 1'b0, 4'd2, 8'h00);
      tick();
      valid = '0;
      check("R4 read strobe port 1", 32'(rd_valid), 32'h2);
      check("R4 read data addr 2", 32'(rd_data), 32'hA2);
      tick();
      check("R4 strobe lasts one cycle", 32'(rd_valid), 32'h0);
   endtask

   task automatic t_plain();
      put(2, 1'b1, 1'b0, 4'd3, 8'h33);
      #1;
      check("R7 plain access granted", 32'(ready), 32'h4);
      tick();
      valid = '0;
      put(0, 1'b1, 1'b0, 4'd4, 8'h44);
      #1;
      check("R7 no hold after plain access", 32'(ready), 32'h1);
      tick();
      valid = '0;
      tick();
   endtask

   task automatic t_atomic();
      put(1, 1'b0, 1'b1, 4'd5, 8'h00);
      #1;
      check("R5 flagged read granted", 32'(ready), 32'h2);
      tick();
      drop(1);
      check("R5 flagged read data", 32'(rd_data), 32'h5A);
      put(0, 1'b1, 1'b0, 4'd10, 8'hB0);
      put(2, 1'b1, 1'b0, 4'd11, 8'hB2);
      #1;
      check("R10 idle owner keeps hold", 32'(ready), 32'h0);
      tick();
      put(1, 1'b1, 1'b1, 4'd12, 8'hC1);
      #1;
      check("R8 second flagged request to owner", 32'(ready), 32'h2);
      tick();
      put(1, 1'b1, 1'b0, 4'd12, 8'hD1);
      #1;
      check("R5 others stalled, closing request served", 32'(ready), 32'h2);
      tick();
      drop(1);
      #1;
      check("R6 hold released, next port granted", 32'(ready), 32'h4);
      tick();
      #1;
      check("R6 rotation resumes", 32'(ready), 32'h1);
      tick();
      valid = '0;
      put(1, 1'b0, 1'b0, 4'd12, 8'h00);
      tick();
      valid = '0;
      check("R6 closing write landed", 32'(rd_data), 32'hD1);
      tick();
   endtask

   task automatic t_test_and_set();
      int w;
      int l;
      put(0, 1'b1, 1'b0, 4'd9, 8'h00);
      tick();
      valid = '0;
      put(0, 1'b0, 1'b1, 4'd9, 8'h00);
      put(2, 1'b0, 1'b1, 4'd9, 8'h00);
      #1;
      check("R9 one contender wins", 32'($countones(ready)), 32'd1);
      w = ready[0] ? 0 : 2;
      l = (w == 0) ? 2 : 0;
      tick();
      check("R9 winner strobe", 32'(rd_valid), 32'(1 << w));
      check("R9 winner reads flag clear", 32'(rd_data), 32'h00);
      put(w, 1'b1, 1'b0, 4'd9, 8'h01);
      #1;
      check("R9 loser blocked during sequence", 32'(ready), 32'(1 << w));
      tick();
      drop(w);
      #1;
      check("R9 loser granted after release", 32'(ready), 32'(1 << l));
      tick();
      check("R9 loser reads flag set", 32'(rd_data), 32'h01);
      check("R9 loser strobe", 32'(rd_valid), 32'(1 << l));
      put(l, 1'b0, 1'b0, 4'd9, 8'h00);
      #1;
      check("R6 loser closes its hold", 32'(ready), 32'(1 << l));
      tick();
      valid = '0;
      put(1, 1'b1, 1'b0, 4'd0, 8'h11);
      #1;
      check("R6 third port free after close", 32'(ready), 32'h2);
      tick();
      valid = '0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog all requirements actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_round_robin();
      t_read_write();
      t_plain();
      t_atomic();
      t_test_and_set();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule